// File: doc/BRIEF.md
# Transparent Translation Window Matcher

This block decides, for one memory unit, whether an access falls inside one of two programmable windows that bypass page-table translation. Each window is described by an enable bit, an 8-bit base, an 8-bit don't-care mask, a 2-bit privilege selector and a write-protect bit. The top eight bits of the logical address, together with the access privilege, are compared against every enabled window.

When a window matches, the access is passed through with the physical address equal to the logical address. If both windows match, window 0 wins and its write-protect setting applies. A write or a locked read-modify-write that lands in a write-protected window raises an abort. Every output is combinational and is forced to zero while the request strobe is low.

Top module: `tt_window_matcher`

## Requirements
- R1: A window whose enable bit is 0 never matches, whatever its other fields hold.
- R2: An enabled window matches only when, for each bit i of 0..7, mask bit i is 1 or address bit 24+i equals base bit i. Masked bits need not be contiguous.
- R3: The privilege selector is 2 bits: 00 matches only user accesses (priv_super_i=0), 01 matches only supervisor accesses (priv_super_i=1), and 10 or 11 matches both.
- R4: When both windows match, hit_idx_o is 0 and the write-protect bit of window 0 decides the abort.
- R5: abort_o is 1 exactly when a window is hit, the selected window's write-protect bit is 1, and wr_i or rmw_lock_i is 1.
- R6: While hit_o is 1, phys_addr_o equals addr_i; otherwise phys_addr_o is 0.
- R7: While req_i is 0, hit_o, hit_idx_o, phys_addr_o and abort_o are all 0.
- R8: When no window matches, hit_idx_o is 0 and abort_o is 0.
- R9: Address bits 23..0 have no influence on hit_o, hit_idx_o or abort_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_i | input | 1 | Access request strobe |
| addr_i | input | 32 | Logical address |
| priv_super_i | input | 1 | 1 for supervisor access, 0 for user |
| wr_i | input | 1 | Write access |
| rmw_lock_i | input | 1 | Locked read-modify-write access |
| win_en_i | input | 2 | Enable bit per window (bit k = window k) |
| win_base_i | input | 16 | Base per window, window k in bits 8k+7..8k |
| win_mask_i | input | 16 | Don't-care mask per window, window k in bits 8k+7..8k |
| win_priv_i | input | 4 | Privilege selector per window, window k in bits 2k+1..2k |
| win_wp_i | input | 2 | Write-protect bit per window |
| hit_o | output | 1 | Some window matched |
| hit_idx_o | output | 1 | Index of the window used |
| phys_addr_o | output | 32 | Untranslated physical address |
| abort_o | output | 1 | Protected store aborted |

## Verification
Every result is combinational, so each one is due in the same cycle as the stimulus, with no register between input and output. The bench applies a vector, waits half a clock period for the logic to settle, then samples all four outputs before the next vector is driven. An exhaustive sweep of the eight compared address bits under a non-contiguous mask, directed privilege and priority cases, and a long pseudo-random sweep of window settings are each compared against a model written as a masked XOR, not a per-bit loop.

// File: rtl/tt_pkg.sv
package tt_pkg;

  // Privilege selector values; any value with bit 1 set accepts both modes
  typedef enum logic [1:0] {
    PRIV_USER_ONLY  = 2'b00,
    PRIV_SUPER_ONLY = 2'b01,
    PRIV_EITHER     = 2'b10,
    PRIV_EITHER_ALT = 2'b11
  } priv_sel_e;

  // True when the access privilege is accepted by the selector
  function automatic logic priv_accepts(input logic [1:0] sel, input logic is_super);
    logic ok;
    case (sel)
      PRIV_USER_ONLY:  ok = ~is_super;
      PRIV_SUPER_ONLY: ok = is_super;
      default:         ok = 1'b1;
    endcase
    return ok;
  endfunction

  // A store is any access that write protection must stop
  function automatic logic is_store(input logic wr, input logic rmw);
    return wr | rmw;
  endfunction

endpackage

// File: rtl/tt_window_cmp.sv
module tt_window_cmp #(
  parameter int unsigned CMP_W = 8
) (
  input  logic             en_i,
  input  logic [CMP_W-1:0] base_i,
  input  logic [CMP_W-1:0] mask_i,
  input  logic [1:0]       priv_sel_i,
  input  logic [CMP_W-1:0] addr_hi_i,
  input  logic             is_super_i,
  output logic             hit_o
);
  import tt_pkg::*;

  logic [CMP_W-1:0] bit_ok;

  for (genvar b = 0; b < CMP_W; b++) begin : g_bit
    assign bit_ok[b] = mask_i[b] | (addr_hi_i[b] == base_i[b]);
  end

  assign hit_o = en_i & (&bit_ok) & priv_accepts(priv_sel_i, is_super_i);

endmodule

// File: rtl/tt_prio_sel.sv
module tt_prio_sel #(
  parameter int unsigned NUM_WIN = 2,
  parameter int unsigned IDX_W   = 1
) (
  input  logic [NUM_WIN-1:0] hits_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  assign any_o = |hits_i;

  // Lowest index wins: scan downward so the last assignment is the lowest hit
  always_comb begin
    idx_o = '0;
    for (int k = NUM_WIN - 1; k >= 0; k--) begin
      if (hits_i[k]) idx_o = k[IDX_W-1:0];
    end
  end

endmodule

// File: rtl/tt_window_matcher.sv
module tt_window_matcher #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned CMP_W   = 8,
  parameter int unsigned NUM_WIN = 2,
  localparam int unsigned IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                     req_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     priv_super_i,
  input  logic                     wr_i,
  input  logic                     rmw_lock_i,
  input  logic [NUM_WIN-1:0]       win_en_i,
  input  logic [NUM_WIN*CMP_W-1:0] win_base_i,
  input  logic [NUM_WIN*CMP_W-1:0] win_mask_i,
  input  logic [NUM_WIN*2-1:0]     win_priv_i,
  input  logic [NUM_WIN-1:0]       win_wp_i,
  output logic                     hit_o,
  output logic [IDX_W-1:0]         hit_idx_o,
  output logic [ADDR_W-1:0]        phys_addr_o,
  output logic                     abort_o
);
  import tt_pkg::*;

  logic [CMP_W-1:0]   addr_hi;
  logic [NUM_WIN-1:0] win_hit;     // per-window match, exposed for the checker
  logic               any_hit;
  logic [IDX_W-1:0]   sel_idx;
  logic               sel_wp;
  logic               store_blocked;

  assign addr_hi = addr_i[ADDR_W-1 -: CMP_W];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    tt_window_cmp #(.CMP_W(CMP_W)) cmp_i (
      .en_i       (win_en_i[w]),
      .base_i     (win_base_i[w*CMP_W +: CMP_W]),
      .mask_i     (win_mask_i[w*CMP_W +: CMP_W]),
      .priv_sel_i (win_priv_i[w*2 +: 2]),
      .addr_hi_i  (addr_hi),
      .is_super_i (priv_super_i),
      .hit_o      (win_hit[w])
    );
  end

  tt_prio_sel #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) prio_i (
    .hits_i (win_hit),
    .any_o  (any_hit),
    .idx_o  (sel_idx)
  );

  assign sel_wp        = win_wp_i[sel_idx];
  assign store_blocked = any_hit & sel_wp & is_store(wr_i, rmw_lock_i);

  assign hit_o       = req_i & any_hit;
  assign hit_idx_o   = req_i ? sel_idx : '0;
  assign phys_addr_o = hit_o ? addr_i : '0;
  assign abort_o     = req_i & store_blocked;

endmodule

module tt_window_matcher_chk #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned NUM_WIN = 2,
  parameter int unsigned IDX_W   = 1
) (
  input logic                 req_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic                 wr_i,
  input logic                 rmw_lock_i,
  input logic [NUM_WIN-1:0]   win_en_i,
  input logic [NUM_WIN-1:0]   win_hit,
  input logic                 hit_o,
  input logic [IDX_W-1:0]     hit_idx_o,
  input logic [ADDR_W-1:0]    phys_addr_o,
  input logic                 abort_o
);
  always_comb begin
    // R7
    req_low_quiet_chk: assert (req_i || (!hit_o && hit_idx_o == '0 && phys_addr_o == '0 && !abort_o))
      else $error("outputs active without request");
    // R5
    abort_needs_store_chk: assert (!abort_o || (hit_o && (wr_i || rmw_lock_i)))
      else $error("abort without hit or store");
    // R4
    win0_priority_chk: assert (!(req_i && win_hit[0]) || hit_idx_o == '0)
      else $error("window 0 hit but not selected");
    // R8
    miss_idx_zero_chk: assert (hit_o || (hit_idx_o == '0 && !abort_o))
      else $error("index or abort set on a miss");
    // R1
    sel_enabled_chk: assert (!hit_o || win_en_i[hit_idx_o])
      else $error("selected window is disabled");
    // R6
    phys_passthru_chk: assert (!hit_o || phys_addr_o == addr_i)
      else $error("physical address differs from logical");
  end
endmodule

bind tt_window_matcher tt_window_matcher_chk #(
  .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .IDX_W(IDX_W)
) chk_i (
  .req_i(req_i), .addr_i(addr_i), .wr_i(wr_i), .rmw_lock_i(rmw_lock_i),
  .win_en_i(win_en_i), .win_hit(win_hit), .hit_o(hit_o), .hit_idx_o(hit_idx_o),
  .phys_addr_o(phys_addr_o), .abort_o(abort_o)
);

// File: tb/tt_window_matcher_tb.sv
module tt_window_matcher_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic        req, sup, wr, rmw;
  logic [31:0] addr;
  logic [1:0]  en, wp;
  logic [15:0] base, mask;
  logic [3:0]  priv;
  logic        hit, idx, abort;
  logic [31:0] phys;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  tt_window_matcher dut_i (
    .req_i(req), .addr_i(addr), .priv_super_i(sup), .wr_i(wr), .rmw_lock_i(rmw),
    .win_en_i(en), .win_base_i(base), .win_mask_i(mask), .win_priv_i(priv),
    .win_wp_i(wp), .hit_o(hit), .hit_idx_o(idx), .phys_addr_o(phys), .abort_o(abort)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (addr %h sup %b en %b base %h mask %h priv %h wp %b)",
               tag, act, exp, addr, sup, en, base, mask, priv, wp);
    end
  endtask

  // Model: masked XOR on the top byte, privilege by selector rules
  function automatic bit model_win(int k);
    logic [7:0] diff;
    logic [1:0] s;
    diff = (addr[31:24] ^ base[8*k +: 8]) & ~mask[8*k +: 8];
    s = priv[2*k +: 2];
    return en[k] && diff == 8'h00 && (s[1] || s[0] == sup);
  endfunction

  // Sample half a period after driving, then compare all outputs
  task automatic apply_and_check(input string tag);
    bit m0, m1, eh, ei, ea;
    #10;
    m0 = model_win(0);
    m1 = model_win(1);
    eh = req && (m0 || m1);
    ei = eh && !m0;
    ea = eh && (m0 ? wp[0] : wp[1]) && (wr || rmw);
    chk({tag, " hit"},   {31'd0, hit},   {31'd0, eh});
    chk({tag, " idx"},   {31'd0, idx},   {31'd0, ei});
    chk({tag, " abort"}, {31'd0, abort}, {31'd0, ea});
    chk({tag, " phys"},  phys,           eh ? addr : 32'd0);
    #10;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] lfsr;
    req = 0; sup = 0; wr = 0; rmw = 0; addr = 32'h0;
    en = 2'b11; base = 16'h0000; mask = 16'hFFFF; priv = 4'hA; wp = 2'b11;

    // R7: idle request, windows would match everything
    wr = 1; addr = 32'h1234_5678;
    apply_and_check("R7 idle");

    // R3: user-space window (mask FF, user-only) on window 0 only
    req = 1; wr = 0; en = 2'b01; mask = 16'h00FF; priv = 4'h0; wp = 2'b00;
    addr = 32'hDEAD_BEEF; sup = 0; apply_and_check("R3 user ok");
    sup = 1;                       apply_and_check("R3 user rejects super");
    // R3: supervisor window 0x00-0x0F, write protected, on window 1
    en = 2'b10; base = 16'h0000; mask = 16'h0F00; priv = 4'h4; wp = 2'b10; wr = 1;
    addr = 32'h0FFF_FFFF; sup = 1; apply_and_check("R3 R5 super low");
    addr = 32'h1000_0000;          apply_and_check("R2 super out of range");
    addr = 32'h0000_0000; sup = 0; apply_and_check("R3 super rejects user");
    priv = 4'hC;                   apply_and_check("R3 either mode 11");
    wr = 0; rmw = 1;               apply_and_check("R5 locked rmw aborts");
    rmw = 0;                       apply_and_check("R5 read not aborted");

    // R1: disabled windows with matching fields
    en = 2'b00; mask = 16'hFFFF; priv = 4'hA; wr = 1;
    apply_and_check("R1 both disabled");
    // R4: both match, window 0 unprotected, window 1 protected
    en = 2'b11; wp = 2'b10;        apply_and_check("R4 priority no abort");
    wp = 2'b01;                    apply_and_check("R4 priority abort");

    // R2 R9: exhaustive top byte, non-contiguous mask, varying low bits
    en = 2'b11; base = 16'h3C5A; mask = 16'h8124; priv = 4'h9; wp = 2'b01;
    for (int a = 0; a < 256; a++) begin
      for (int s = 0; s < 2; s++) begin
        addr = {a[7:0], 24'(a * 40503 + s * 977)};
        sup = s[0]; wr = a[0]; rmw = a[1];
        apply_and_check("R2 R9 sweep");
      end
    end

    // R1..R9 pseudo-random configuration sweep
    lfsr = 32'hACE1_2024;
    for (int i = 0; i < 12000; i++) begin
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;  addr = lfsr;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      base = lfsr[15:0]; mask = lfsr[31:16] & lfsr[23:8];
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      en = lfsr[1:0] | {1'b0, lfsr[9]}; priv = lfsr[7:4]; wp = lfsr[11:10];
      sup = lfsr[12]; wr = lfsr[13]; rmw = lfsr[14] & lfsr[15];
      req = lfsr[16] | lfsr[17] | lfsr[18];
      if (lfsr[19]) base[15:8] = addr[31:24] ^ (lfsr[27:20] & mask[15:8]);
      if (lfsr[28]) base[7:0]  = addr[31:24] ^ (lfsr[27:20] & mask[7:0]);
      apply_and_check("R1-R9 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    done = 1;
    $finish;
  end
endmodule